// File: doc/BRIEF.md
# Dual-Rail Token Prefix Adder

This block adds two W-bit operands and a carry-in, all presented as dual-rail tokens, and returns a W-bit dual-rail sum and a dual-rail carry-out. Inside, each bit position is reduced to a one-hot kill/propagate/generate status. A parallel-prefix tree then combines these statuses into group statuses, and a final stage forms the sum from a dual-rail exclusive-or and the resolved carries. The operand bits are copied in the first stage: one copy feeds the carry path and the other feeds the sum path.

Each pipeline stage is a clocked buffer that holds one token. A stage takes a new token only when it is empty or when its current token leaves in the same cycle. Several additions can therefore be in flight at once. The operand side and the result side each use a valid/ready handshake. When a stage holds no token, all of its rails are low.

Top module: `dr_kpg_prefix_adder`

## Requirements
- R1: On every dual-rail port, a high one-rail means 1, a high zero-rail means 0, and both rails low means no token. While `out_valid` is high, every sum bit and the carry-out have exactly one high rail. While `out_valid` is low, all output rails are low.
- R2: The per-bit status is generate = a1·b1, kill = a0·b0 and propagate = a0·b1 + a1·b0. At most one of the three is high for any bit.
- R3: Combining a higher group (k,p,g)hi with a lower group (k,p,g)lo gives k = khi + phi·klo, p = phi·plo and g = ghi + phi·glo.
- R4: The carry out of bit j has one-rail G(j:0) + P(j:0)·cin1 and zero-rail K(j:0) + P(j:0)·cin0. It is resolved at the first prefix level whose span covers bit j.
- R5: Sum bit j has zero-rail L0·c0 + L1·c1 and one-rail L1·c0 + L0·c1. Here L is the dual-rail exclusive-or of a and b at bit j, and c is the carry into bit j (cin for bit 0).
- R6: The unsigned value {cout, sum} equals a + b + cin for every pair of operands and both carry-in values.
- R7: The pipeline is 2 + log2(W) + 1 stages deep. With the output never stalled, a token accepted at a clock edge shows on the result port that many edges later.
- R8: While `out_ready` is high, `in_ready` is high, so one addition is accepted every cycle.
- R9: While `out_valid` is high and `out_ready` is low, the result stays valid and unchanged. Results leave in the order the operands were accepted, and none is lost or duplicated.
- R10: With the output stalled, the block accepts exactly 2 + log2(W) + 1 tokens, then holds `in_ready` low.
- R11: Operand rails presented while `in_valid` is low create no token, and they never reach the result port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; empties every stage |
| in_valid | input | 1 | Operand token offered |
| in_ready | output | 1 | Operand token taken at the clock edge when both are high |
| a_one | input | W | Operand A, one-rails |
| a_zero | input | W | Operand A, zero-rails |
| b_one | input | W | Operand B, one-rails |
| b_zero | input | W | Operand B, zero-rails |
| cin_one | input | 1 | Carry-in, one-rail |
| cin_zero | input | 1 | Carry-in, zero-rail |
| out_valid | output | 1 | Result token present |
| out_ready | input | 1 | Result taken at the clock edge when both are high |
| sum_one | output | W | Sum, one-rails |
| sum_zero | output | W | Sum, zero-rails |
| cout_one | output | 1 | Carry-out, one-rail |
| cout_zero | output | 1 | Carry-out, zero-rail |

## Verification
The two functions that can meet in one cycle are a stage draining its token to the next stage and the same stage loading a new token. They meet whenever the pipeline is busy and the result port is drained in the same cycle. The bench provokes this in two ways. It sweeps every operand pair back to back with the output always ready, and it sweeps them again with random result stalls and input bubbles, so that loads and drains line up at every depth. The outcome is judged by comparing each result, in order, against an arithmetic sum kept in a queue in the bench. A stall-only fill then checks that the block stops accepting at exactly its depth.

// File: rtl/dr_kpg_prefix_adder.sv
module dr_kpg_prefix_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] a_one,
  input  logic [W-1:0] a_zero,
  input  logic [W-1:0] b_one,
  input  logic [W-1:0] b_zero,
  input  logic         cin_one,
  input  logic         cin_zero,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] sum_one,
  output logic [W-1:0] sum_zero,
  output logic         cout_one,
  output logic         cout_zero
);
  localparam int LG = $clog2(W);
  localparam int NS = LG + 3;

  logic [NS-1:0] vld;
  logic [NS:0]   adv;

  assign adv[NS] = out_ready;
  genvar gi;
  generate
    for (gi = 0; gi < NS; gi++) begin : g_adv
      assign adv[gi] = !vld[gi] || adv[gi+1];
    end
  endgenerate
  assign in_ready  = adv[0];
  assign out_valid = vld[NS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else begin
      if (adv[0]) vld[0] <= in_valid;
      for (int i = 1; i < NS; i++)
        if (adv[i]) vld[i] <= vld[i-1];
    end
  end

  // stage 0: copy operands, one set for the carry path, one for the sum path
  logic [W-1:0] ca1, ca0, cb1, cb0, sa1, sa0, sb1, sb0;
  logic         ci1_d, ci0_d;
  wire  [W-1:0] gate = {W{in_valid}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ca1, ca0, cb1, cb0, sa1, sa0, sb1, sb0} <= '0;
      {ci1_d, ci0_d} <= '0;
    end else if (adv[0]) begin
      ca1 <= a_one & gate;  ca0 <= a_zero & gate;
      cb1 <= b_one & gate;  cb0 <= b_zero & gate;
      sa1 <= a_one & gate;  sa0 <= a_zero & gate;
      sb1 <= b_one & gate;  sb0 <= b_zero & gate;
      ci1_d <= cin_one & in_valid;
      ci0_d <= cin_zero & in_valid;
    end
  end

  // level arrays: index 0 is the bit-status stage, index x is prefix level x
  logic [W-1:0] kq [0:LG];
  logic [W-1:0] pq [0:LG];
  logic [W-1:0] gq [0:LG];
  logic [W-1:0] c1q[0:LG];
  logic [W-1:0] c0q[0:LG];
  logic [W-1:0] l1q[0:LG];
  logic [W-1:0] l0q[0:LG];
  logic         ci1q[0:LG];
  logic         ci0q[0:LG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kq[0] <= '0; pq[0] <= '0; gq[0] <= '0;
      c1q[0] <= '0; c0q[0] <= '0; l1q[0] <= '0; l0q[0] <= '0;
      ci1q[0] <= 1'b0; ci0q[0] <= 1'b0;
    end else if (adv[1]) begin
      kq[0]   <= ca0 & cb0;
      gq[0]   <= ca1 & cb1;
      pq[0]   <= (ca0 & cb1) | (ca1 & cb0);
      l1q[0]  <= (sa0 & sb1) | (sa1 & sb0);
      l0q[0]  <= (sa0 & sb0) | (sa1 & sb1);
      c1q[0]  <= '0;
      c0q[0]  <= '0;
      ci1q[0] <= ci1_d;
      ci0q[0] <= ci0_d;
    end
  end

  generate
    for (gi = 1; gi <= LG; gi++) begin : g_lvl
      localparam int SP = 1 << (gi - 1);
      logic [W-1:0] nk, np, ng, nc1, nc0;

      always_comb begin
        for (int j = 0; j < W; j++) begin
          int lo;
          lo = (j >= SP) ? j - SP : 0;
          if (j >= SP) begin
            nk[j] = kq[gi-1][j] | (pq[gi-1][j] & kq[gi-1][lo]);
            np[j] = pq[gi-1][j] & pq[gi-1][lo];
            ng[j] = gq[gi-1][j] | (pq[gi-1][j] & gq[gi-1][lo]);
          end else begin
            nk[j] = kq[gi-1][j];
            np[j] = pq[gi-1][j];
            ng[j] = gq[gi-1][j];
          end
          if (j < 2 * SP) begin
            nc1[j] = ng[j] | (np[j] & ci1q[gi-1]);
            nc0[j] = nk[j] | (np[j] & ci0q[gi-1]);
          end else begin
            nc1[j] = c1q[gi-1][j];
            nc0[j] = c0q[gi-1][j];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          kq[gi] <= '0; pq[gi] <= '0; gq[gi] <= '0;
          c1q[gi] <= '0; c0q[gi] <= '0; l1q[gi] <= '0; l0q[gi] <= '0;
          ci1q[gi] <= 1'b0; ci0q[gi] <= 1'b0;
        end else if (adv[gi+1]) begin
          kq[gi]   <= nk;
          pq[gi]   <= np;
          gq[gi]   <= ng;
          c1q[gi]  <= nc1;
          c0q[gi]  <= nc0;
          l1q[gi]  <= l1q[gi-1];
          l0q[gi]  <= l0q[gi-1];
          ci1q[gi] <= ci1q[gi-1];
          ci0q[gi] <= ci0q[gi-1];
        end
      end
    end
  endgenerate

  // final stage: sum from exclusive-or and carry into each bit
  wire [W-1:0] cin1_v = {c1q[LG][W-2:0], ci1q[LG]};
  wire [W-1:0] cin0_v = {c0q[LG][W-2:0], ci0q[LG]};
  logic [W-1:0] s1r, s0r;
  logic         co1r, co0r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1r <= '0; s0r <= '0; co1r <= 1'b0; co0r <= 1'b0;
    end else if (adv[NS-1]) begin
      s0r  <= (l0q[LG] & cin0_v) | (l1q[LG] & cin1_v);
      s1r  <= (l1q[LG] & cin0_v) | (l0q[LG] & cin1_v);
      co1r <= c1q[LG][W-1];
      co0r <= c0q[LG][W-1];
    end
  end

  assign sum_one   = s1r;
  assign sum_zero  = s0r;
  assign cout_one  = co1r;
  assign cout_zero = co0r;
endmodule

// File: rtl/dr_kpg_prefix_adder_chk.sv
module dr_kpg_prefix_adder_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] a_one,
  input logic [W-1:0] a_zero,
  input logic [W-1:0] b_one,
  input logic [W-1:0] b_zero,
  input logic         cin_one,
  input logic         cin_zero,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] sum_one,
  input logic [W-1:0] sum_zero,
  input logic         cout_one,
  input logic         cout_zero,
  input logic [W-1:0] fk,
  input logic [W-1:0] fp,
  input logic [W-1:0] fg
);
  p_in_dual_rail_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((a_one ^ a_zero) == '1) && ((b_one ^ b_zero) == '1) && (cin_one ^ cin_zero));

  p_out_dual_rail_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((sum_one ^ sum_zero) == '1) && (cout_one ^ cout_zero));

  p_out_null_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (sum_one == '0) && (sum_zero == '0) && !cout_one && !cout_zero);

  p_kpg_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((fk & fp) | (fk & fg) | (fp & fg)) == '0);

  p_full_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(sum_one) && $stable(sum_zero)
                                && $stable(cout_one) && $stable(cout_zero));
endmodule

bind dr_kpg_prefix_adder dr_kpg_prefix_adder_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .a_one(a_one), .a_zero(a_zero), .b_one(b_one), .b_zero(b_zero),
  .cin_one(cin_one), .cin_zero(cin_zero), .out_valid(out_valid), .out_ready(out_ready),
  .sum_one(sum_one), .sum_zero(sum_zero), .cout_one(cout_one), .cout_zero(cout_zero),
  .fk(kq[LG]), .fp(pq[LG]), .fg(gq[LG])
);

// File: tb/tb_dr_kpg_prefix_adder.sv
module tb_dr_kpg_prefix_adder;
  localparam int W  = 4;
  localparam int NS = $clog2(W) + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, in_ready, out_valid;
  logic [W-1:0] a_one = '0, a_zero = '0, b_one = '0, b_zero = '0;
  logic cin_one = 1'b0, cin_zero = 1'b0;
  logic [W-1:0] sum_one, sum_zero;
  logic cout_one, cout_zero;

  always #2 clk = ~clk;

  dr_kpg_prefix_adder #(.W(W)) dut (.*);

  int checks = 0, fails = 0;
  logic [W:0] expq [0:2047];
  int hd = 0, tl = 0;
  logic seen_out;
  logic took;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic ci, input logic ordy, output logic tk);
    @(posedge clk); #1;
    in_valid = iv;
    a_one = a; a_zero = ~a; b_one = b; b_zero = ~b;
    cin_one = ci; cin_zero = ~ci;
    out_ready = ordy;
    #2;
    seen_out = out_valid;
    tk = in_valid && in_ready;
    if (out_valid && out_ready) begin
      if (hd == tl) chk(1'b0, "R9 extra result", {cout_one, sum_one}, -1);
      else begin
        // R6 value, R1 rail encoding, R9 order
        chk(({cout_one, sum_one} == expq[hd]) && (sum_zero == ~sum_one) && (cout_zero != cout_one),
            "R6 sum", {cout_one, sum_one}, expq[hd]);
        hd++;
      end
    end
    if (tk) begin
      expq[tl] = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
      tl++;
    end
  endtask

  task automatic drain(input logic stall);
    for (int n = 0; n < 400 && hd != tl; n++)
      step(1'b0, '0, '0, 1'b0, stall ? ($urandom % 3 != 0) : 1'b1, took);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int lat, misses, acc;
    logic [W-1:0] ga, gb;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    chk(!out_valid && sum_one == '0 && sum_zero == '0 && !cout_one && !cout_zero,
        "R1 reset null", out_valid, 0);
    chk(in_ready, "R8 reset ready", in_ready, 1);

    // R7 latency of one token
    step(1'b1, 4'd3, 4'd5, 1'b0, 1'b1, took);
    lat = 0;
    for (int n = 1; n < 20 && lat == 0; n++) begin
      step(1'b0, '0, '0, 1'b0, 1'b1, took);
      if (seen_out) lat = n;
    end
    chk(lat == NS, "R7 latency", lat, NS);
    drain(1'b0);

    // R2 R3 R4 R5 R6 R8: exhaustive, back to back, no stalls
    misses = 0;
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        for (int c = 0; c < 2; c++) begin
          step(1'b1, a[W-1:0], b[W-1:0], c[0], 1'b1, took);
          if (!took) misses++;
        end
    chk(misses == 0, "R8 full rate", misses, 0);
    drain(1'b0);
    chk(hd == tl, "R6 all returned", tl - hd, 0);

    // R9: exhaustive again under random stalls and bubbles
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        for (int c = 0; c < 2; c++) begin
          took = 1'b0;
          while (!took) begin
            if ($urandom % 5 == 0) step(1'b0, '0, '0, 1'b0, $urandom % 3 != 0, took);
            step(1'b1, a[W-1:0], b[W-1:0], c[0], $urandom % 3 != 0, took);
          end
        end
    drain(1'b1);
    chk(hd == tl, "R9 none lost", tl - hd, 0);

    // R10: capacity under a full stall
    acc = 0;
    for (int n = 0; n < NS + 6; n++) begin
      step(1'b1, n[W-1:0], 4'd9, n[0], 1'b0, took);
      if (took) acc++;
    end
    chk(acc == NS, "R10 capacity", acc, NS);
    chk(!in_ready, "R10 full stall", in_ready, 0);
    chk(out_valid, "R9 held valid", out_valid, 1);
    drain(1'b0);
    chk(hd == tl, "R10 drained", tl - hd, 0);

    // R11: rails presented without in_valid create nothing
    for (int n = 0; n < NS + 4; n++) begin
      ga = $urandom; gb = $urandom;
      step(1'b0, ga, gb, ga[0], 1'b1, took);
      chk(!seen_out && sum_one == '0 && sum_zero == '0 && !cout_one && !cout_zero,
          "R11 no token", seen_out, 0);
    end
    chk(hd == tl, "R11 queue empty", tl - hd, 0);
    finish_run();
  end
endmodule